// File: doc/BRIEF.md
# Key-guarded control register bank

This block holds the 32-bit control words of a clock-management peripheral behind a simple register bus. Each write must carry an 8-bit unlock code in the top byte of its data. When the code matches, the word is stored with that byte cleared, so the code never reads back. When the code does not match, the register stays as it was and a sticky flag records the attempt.

The bank decodes a 0x2000-byte window. Only the first `NUM_REGS` words hold storage. The last word of the window is the flag word. The other words in the window read as zero and discard writes. Only full, aligned 32-bit accesses are legal. Any other access gets an error response and changes nothing.

There is no back-pressure on the bus. A strobe is taken in the cycle it is high. Exactly one cycle later the block returns a one-cycle acknowledge, with the error flag and the read data.

Top module: `keyreg_bank`

## Requirements
- R1: After reset, every storage word and the flag word read as zero, and `bus_ack` and `bus_err` are low.
- R2: A legal write whose bits [31:24] equal `UNLOCK` (default 8'h5A) stores the data with bits [31:24] forced to zero. A read issued in the very next cycle returns the new value.
- R3: A legal write whose bits [31:24] differ from `UNLOCK` leaves the addressed word unchanged and gets no error.
- R4: Every legal write with a mismatched code sets bit 0 of the flag word (byte offset 0x1FFC), whatever its address. The other bits of the flag word read as zero.
- R5: The flag is cleared only by a legal write to offset 0x1FFC with a matching code and data bit 0 set. A matching write with bit 0 clear, or any read, leaves the flag set.
- R6: An access with `bus_be` other than 4'b1111 gets `bus_err` and changes no word and no flag.
- R7: An access with `bus_addr[1:0]` nonzero gets `bus_err` and changes no word and no flag.
- R8: Word indices from `NUM_REGS` up to the last word but one read as zero and ignore writes with a matching code. These accesses get no error.
- R9: Each strobe gives exactly one `bus_ack` pulse one cycle later. `bus_ack` is never high without a strobe in the previous cycle, and `bus_err` is high only together with `bus_ack`.
- R10: When `bus_wr` and `bus_rd` are both high, the access gets `bus_err` and changes nothing.
- R11: Reads have no side effects: reading the same word twice returns the same value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, synchronous |
| bus_addr | input | 13 | Byte offset in the window |
| bus_wdata | input | 32 | Write data, with the unlock code in [31:24] |
| bus_be | input | 4 | Byte enables; only 4'b1111 is legal |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_rdata | output | 32 | Data of the last legal read, valid with `bus_ack` |
| bus_ack | output | 1 | Response pulse, one cycle after a strobe |
| bus_err | output | 1 | Error response for an illegal access |

## Verification
The assertions assume the strobes and the address, data and byte-enable inputs are known (never X) in every cycle after reset. They also assume reset is held low for at least one clock edge before the first access. The bench drives all inputs at the falling clock edge. It releases the bus to all-zero between bursts and starts its first access only after reset has been released. Back-to-back strobes, overlapping read and write strobes, and illegal byte enables are driven on purpose, so the error and flag properties see every case they cover.

// File: rtl/keyreg_pkg.sv
package keyreg_pkg;
  typedef struct packed {
    logic legal;
    logic key_ok;
    logic in_range;
    logic is_flag;
  } acc_dec_t;

  function automatic logic [31:0] field_mask(input int msb, input int lsb);
    logic [31:0] m;
    for (int b = 0; b < 32; b++) m[b] = (b <= msb) && (b >= lsb);
    return m;
  endfunction
endpackage

// File: rtl/keyreg_decode.sv
module keyreg_decode
  import keyreg_pkg::*;
#(
  parameter int ADDR_W   = 13,
  parameter int NUM_REGS = 16,
  parameter int KEY_MSB  = 31,
  parameter int KEY_LSB  = 24,
  parameter int UNLOCK   = 8'h5A
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0]       wdata,
  input  logic [3:0]        be,
  input  logic              wr,
  input  logic              rd,
  output logic [ADDR_W-3:0] idx,
  output acc_dec_t          dec
);
  localparam int IDX_W = ADDR_W - 2;
  localparam int KEY_W = KEY_MSB - KEY_LSB + 1;
  localparam logic [IDX_W-1:0] FLAG_IDX = {IDX_W{1'b1}};

  assign idx = addr[ADDR_W-1:2];

  always_comb begin
    dec.legal    = !(wr && rd) && (be == 4'b1111) && (addr[1:0] == 2'b00);
    dec.key_ok   = wdata[KEY_MSB:KEY_LSB] == KEY_W'(UNLOCK);
    dec.in_range = idx < IDX_W'(NUM_REGS);
    dec.is_flag  = idx == FLAG_IDX;
  end
endmodule

// File: rtl/keyreg_store.sv
module keyreg_store #(
  parameter int NUM_REGS = 16,
  parameter int IDX_W    = 11,
  parameter logic [31:0] KEEP_MASK = 32'h00FF_FFFF
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [IDX_W-1:0] idx,
  input  logic [31:0]      wdata,
  output logic [31:0]      rdata
);
  logic [31:0] word_q [NUM_REGS];

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_word
    always_ff @(posedge clk) begin
      if (!rst_n)                              word_q[g] <= '0;
      else if (we && idx == IDX_W'(g))        word_q[g] <= wdata & KEEP_MASK;
    end
  end

  always_comb begin
    rdata = '0;
    for (int i = 0; i < NUM_REGS; i++)
      if (idx == IDX_W'(i)) rdata = word_q[i];
  end
endmodule

// File: rtl/keyreg_flag.sv
module keyreg_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_q
);
  always_ff @(posedge clk) begin
    if (!rst_n)     flag_q <= 1'b0;
    else if (set_i) flag_q <= 1'b1;
    else if (clr_i) flag_q <= 1'b0;
  end
endmodule

// File: rtl/keyreg_bank.sv
module keyreg_bank
  import keyreg_pkg::*;
#(
  parameter int ADDR_W   = 13,
  parameter int NUM_REGS = 16,
  parameter int KEY_MSB  = 31,
  parameter int KEY_LSB  = 24,
  parameter int UNLOCK   = 8'h5A
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  input  logic [3:0]        bus_be,
  input  logic              bus_wr,
  input  logic              bus_rd,
  output logic [31:0]       bus_rdata,
  output logic              bus_ack,
  output logic              bus_err
);
  localparam int IDX_W = ADDR_W - 2;
  localparam logic [31:0] KEEP_MASK = ~field_mask(KEY_MSB, KEY_LSB);

  logic [IDX_W-1:0] idx;
  acc_dec_t         dec;
  logic [31:0]      store_rd;
  logic             flag_q;
  logic             wr_ok, wr_bad, strobe;

  keyreg_decode #(
    .ADDR_W(ADDR_W), .NUM_REGS(NUM_REGS),
    .KEY_MSB(KEY_MSB), .KEY_LSB(KEY_LSB), .UNLOCK(UNLOCK)
  ) u_dec (
    .addr(bus_addr), .wdata(bus_wdata), .be(bus_be),
    .wr(bus_wr), .rd(bus_rd), .idx(idx), .dec(dec)
  );

  assign strobe = bus_wr || bus_rd;
  assign wr_ok  = bus_wr && dec.legal && dec.key_ok;
  assign wr_bad = bus_wr && dec.legal && !dec.key_ok;

  keyreg_store #(.NUM_REGS(NUM_REGS), .IDX_W(IDX_W), .KEEP_MASK(KEEP_MASK)) u_store (
    .clk(clk), .rst_n(rst_n), .we(wr_ok && dec.in_range),
    .idx(idx), .wdata(bus_wdata), .rdata(store_rd)
  );

  keyreg_flag u_flag (
    .clk(clk), .rst_n(rst_n), .set_i(wr_bad),
    .clr_i(wr_ok && dec.is_flag && bus_wdata[0]), .flag_q(flag_q)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bus_ack   <= 1'b0;
      bus_err   <= 1'b0;
      bus_rdata <= '0;
    end else begin
      bus_ack <= strobe;
      bus_err <= strobe && !dec.legal;
      if (bus_rd && dec.legal)
        bus_rdata <= dec.is_flag  ? {31'b0, flag_q} :
                     dec.in_range ? store_rd : 32'b0;
    end
  end
endmodule

// File: rtl/keyreg_bank_chk.sv
module keyreg_bank_chk #(
  parameter int ADDR_W  = 13,
  parameter int KEY_MSB = 31,
  parameter int KEY_LSB = 24,
  parameter int UNLOCK  = 8'h5A
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [31:0]       bus_wdata,
  input logic [3:0]        bus_be,
  input logic              bus_wr,
  input logic              bus_rd,
  input logic [31:0]       bus_rdata,
  input logic              bus_ack,
  input logic              bus_err,
  input logic              flag_q
);
  localparam int KEY_W = KEY_MSB - KEY_LSB + 1;

  assert_ack_follows_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr || bus_rd) |=> bus_ack);
  assert_no_spurious_ack_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_wr || bus_rd) |=> !bus_ack);
  assert_err_with_ack_R9: assert property (@(posedge clk) disable iff (!rst_n)
    bus_err |-> bus_ack);
  assert_bad_be_err_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ((bus_wr || bus_rd) && bus_be != 4'b1111) |=> bus_err);
  assert_misalign_err_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ((bus_wr || bus_rd) && bus_addr[1:0] != 2'b00) |=> bus_err);
  assert_both_strobes_err_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_rd) |=> bus_err);
  assert_key_reads_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    bus_ack |-> bus_rdata[KEY_MSB:KEY_LSB] == '0);
  assert_flag_sets_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && !bus_rd && bus_be == 4'b1111 && bus_addr[1:0] == 2'b00 &&
     bus_wdata[KEY_MSB:KEY_LSB] != KEY_W'(UNLOCK)) |=> flag_q);
  assert_flag_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q && !bus_wr) |=> flag_q);
endmodule

bind keyreg_bank keyreg_bank_chk #(
  .ADDR_W(ADDR_W), .KEY_MSB(KEY_MSB), .KEY_LSB(KEY_LSB), .UNLOCK(UNLOCK)
) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
  .bus_be(bus_be), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
  .bus_ack(bus_ack), .bus_err(bus_err), .flag_q(flag_q)
);

// File: tb/sim_keyreg_bank.sv
module sim_keyreg_bank;
  localparam int NREG = 16;
  localparam logic [12:0] FLAG_OFS = 13'h1FFC;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [12:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [3:0]  bus_be = '0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [31:0] bus_rdata;
  logic        bus_ack, bus_err;

  int checks = 0, errors = 0;
  logic [31:0] model [NREG];
  logic        mflag = 1'b0;

  logic        q_isrd [$];
  logic [31:0] q_data [$];
  logic        q_err  [$];
  string       q_req  [$];

  always #10 clk = ~clk;

  keyreg_bank u0 (.*);

  task automatic fail(string req, logic [31:0] act, logic [31:0] exp);
    errors++;
    $display("FAIL %s actual=%h expected=%h", req, act, exp);
  endtask

  task automatic access(input logic wr, input logic rd, input logic [12:0] a,
                        input logic [31:0] d, input logic [3:0] be, input string req);
    logic legal;
    logic [31:0] rexp;
    int w;
    @(negedge clk);
    bus_wr = wr; bus_rd = rd; bus_addr = a; bus_wdata = d; bus_be = be;
    legal = !(wr && rd) && be == 4'hF && a[1:0] == 2'b00;
    w = int'(a[12:2]);
    rexp = 32'h0;
    if (legal && rd) begin
      if (a == FLAG_OFS) rexp = {31'b0, mflag};
      else if (w < NREG) rexp = model[w];
    end
    if (legal && wr) begin
      if (d[31:24] != 8'h5A) mflag = 1'b1;
      else if (a == FLAG_OFS) begin if (d[0]) mflag = 1'b0; end
      else if (w < NREG) model[w] = {8'h00, d[23:0]};
    end
    q_isrd.push_back(rd && legal); q_data.push_back(rexp);
    q_err.push_back(!legal); q_req.push_back(req);
  endtask

  task automatic idle();
    @(negedge clk);
    bus_wr = 0; bus_rd = 0; bus_addr = '0; bus_wdata = '0; bus_be = '0;
  endtask

  task automatic wr_key(logic [12:0] a, logic [31:0] d, string req);
    access(1, 0, a, d, 4'hF, req);
  endtask
  task automatic rd_word(logic [12:0] a, string req);
    access(0, 1, a, 32'h0, 4'hF, req);
  endtask

  // monitor / scoreboard
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n && bus_ack) begin
        if (q_err.size() == 0) begin
          checks++; fail("R9 ack without strobe", 1, 0);
        end else begin
          logic isrd, e; logic [31:0] dv; string r;
          isrd = q_isrd.pop_front(); dv = q_data.pop_front();
          e = q_err.pop_front(); r = q_req.pop_front();
          checks++;
          if (bus_err !== e) fail({r, " err"}, 32'(bus_err), 32'(e));
          if (isrd) begin
            checks++;
            if (bus_rdata !== dv) fail({r, " rdata"}, bus_rdata, dv);
          end
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < NREG; i++) model[i] = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    checks++;
    if (bus_ack !== 1'b0 || bus_err !== 1'b0) fail("R1 ack/err at reset", {bus_ack, bus_err}, 0);
    rst_n = 1'b1;
    // R1: all words zero after reset
    for (int i = 0; i < NREG; i++) rd_word(13'(i * 4), "R1");
    rd_word(FLAG_OFS, "R1 flag");
    idle();
    // R2: keyed writes, read-back in next cycle
    wr_key(13'h00C, 32'h5A12_3456, "R2");
    rd_word(13'h00C, "R2 next-cycle read");
    wr_key(13'h03C, 32'h5AFF_FFFF, "R2");
    rd_word(13'h03C, "R2 key stripped");
    wr_key(13'h000, 32'h5A00_00A5, "R2");
    idle();
    rd_word(13'h000, "R2");
    // R3/R4: wrong key
    wr_key(13'h00C, 32'h1387_6543, "R3");
    rd_word(13'h00C, "R3 unchanged");
    rd_word(FLAG_OFS, "R4 flag set");
    rd_word(FLAG_OFS, "R11 read no clear");
    rd_word(13'h00C, "R11 repeat read");
    // R5: clearing
    wr_key(FLAG_OFS, 32'h5A00_0000, "R5 bit0 clear");
    rd_word(FLAG_OFS, "R5 still set");
    wr_key(FLAG_OFS, 32'h5A00_0001, "R5 clear");
    rd_word(FLAG_OFS, "R5 cleared");
    idle();
    // R4: mismatch to out-of-range address also sets flag
    wr_key(13'h0100, 32'hA500_0000, "R4 out-of-range mismatch");
    rd_word(FLAG_OFS, "R4");
    wr_key(FLAG_OFS, 32'h5A00_0001, "R5");
    // R6: bad byte enables
    access(1, 0, 13'h00C, 32'h5A00_0BAD, 4'b0011, "R6 write");
    access(1, 0, 13'h00C, 32'h0000_0BAD, 4'b1110, "R6 bad key no flag");
    access(0, 1, 13'h00C, 32'h0, 4'b0001, "R6 read");
    rd_word(13'h00C, "R6 unchanged");
    rd_word(FLAG_OFS, "R6 flag untouched");
    // R7: misaligned
    access(1, 0, 13'h00D, 32'h5A00_0BAD, 4'hF, "R7 write");
    access(1, 0, 13'h00E, 32'h1100_0BAD, 4'hF, "R7 bad key no flag");
    access(0, 1, 13'h00F, 32'h0, 4'hF, "R7 read");
    rd_word(13'h00C, "R7 unchanged");
    rd_word(FLAG_OFS, "R7 flag untouched");
    idle();
    // R8: unimplemented words
    wr_key(13'h0040, 32'h5A11_1111, "R8");
    rd_word(13'h0040, "R8 reads zero");
    wr_key(13'h1FF8, 32'h5A22_2222, "R8");
    rd_word(13'h1FF8, "R8 reads zero");
    // R10: simultaneous strobes
    access(1, 1, 13'h00C, 32'h5A00_0777, 4'hF, "R10");
    access(1, 1, 13'h00C, 32'h0000_0777, 4'hF, "R10 no flag");
    rd_word(13'h00C, "R10 unchanged");
    rd_word(FLAG_OFS, "R10 flag untouched");
    idle();
    repeat (3) idle();
    checks++;
    if (q_err.size() != 0) fail("R9 missing ack", 32'(q_err.size()), 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule